// File: doc/BRIEF.md
# Parity-Textured Nibble Combine Unit

This unit produces a replacement 4-bit destination pixel from a 4-bit source pixel and the 4-bit pixel currently at the destination. The two pixels form an 8-bit index into a 256-entry table. Each entry is 16 bits wide and holds four candidate result nibbles. The low bits of the destination X and Y coordinates then pick one of the four candidates. Filling the four slots of an entry with different colours lays a 2x2 ordered texture over the destination. This gives more apparent shades than the 16 a single nibble can hold.

Pixels arrive on a valid/ready handshake and are accepted one per cycle. Each accepted pixel's result appears exactly one cycle later, qualified by an output valid pulse. There is no output backpressure. A host loads the table through a write port. A write always wins over a lookup presented in the same cycle, and that lookup is held off until the next cycle. Address generation and the packing of pixels into memory words are left to the surrounding logic. Along one line the caller toggles the X parity from pixel to pixel and keeps the Y parity constant.

Top module: `nibble_texture_combine`

## Requirements
- R1: The table index of a lookup is the source nibble in bits 7:4 and the old destination nibble in bits 3:0.
- R2: Slot 0 of an entry is bits 15:12, slot 1 is bits 11:8, slot 2 is bits 7:4 and slot 3 is bits 3:0.
- R3: The slot used is 2*yOdd + xOdd, taken from the same handshake as the pixel.
- R4: A lookup accepted at a clock edge raises outValid after that edge for exactly one cycle, and outNib then carries its result. Lookups may be accepted on consecutive cycles.
- R5: A host write with wrEn high stores wrData at table address wrAddr. A later lookup of that address returns a nibble of the new data.
- R6: While wrEn is high, inReady is low, no lookup is accepted, and outValid is low in the following cycle.
- R7: While no lookup is accepted, outNib keeps its last value.
- R8: Reset drives outValid low, and outValid stays low until the first accepted lookup.
- R9: In a back-to-back stream with yOdd fixed and xOdd toggling, successive results alternate between the two slots of that row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Pixel offered |
| inReady | output | 1 | Pixel can be taken this cycle (low during a host write) |
| inSrc | input | 4 | Source pixel nibble |
| inDst | input | 4 | Old destination pixel nibble |
| inXOdd | input | 1 | Destination X mod 2 |
| inYOdd | input | 1 | Destination Y mod 2 |
| outValid | output | 1 | Result valid, one cycle after acceptance |
| outNib | output | 4 | New destination nibble |
| wrEn | input | 1 | Host table write strobe |
| wrAddr | input | 8 | Host table write address |
| wrData | input | 16 | Host table write data |

## Verification
On every cycle the assertions check the timing relations. An accepted pixel yields outValid one cycle later, and nothing else does. A host write keeps inReady low. The output nibble does not move between lookups, and reset leaves outValid low. Only the bench scenarios can show the values. These cover the index built from both nibbles, the mapping of each slot to its bit field, the priority of a write over a colliding lookup together with the newly stored data, and the alternation of slots along a line. To check them, the bench compares results against a table it loaded itself.

// File: rtl/nibcomb_pkg.sv
package nibcomb_pkg;
  // Strobes passed from control to datapath each cycle
  typedef struct packed {
    logic tblWrite;  // host write into the table
    logic lookup;    // accepted pixel: read entry, capture slot
  } combStrobe_t;
endpackage

// File: rtl/nibcomb_ctrl.sv
module nibcomb_ctrl
  import nibcomb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        wrEn,
  output logic        inReady,
  output combStrobe_t strobe,
  output logic        outValid
);
  logic validQ;

  // host writes own the table port; pixels wait
  assign inReady         = ~wrEn;
  assign strobe.tblWrite = wrEn;
  assign strobe.lookup   = inValid & ~wrEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validQ <= 1'b0;
    else       validQ <= strobe.lookup;
  end

  assign outValid = validQ;
endmodule

// File: rtl/nibcomb_path.sv
module nibcomb_path
  import nibcomb_pkg::*;
#(
  parameter int PIX_W = 4,
  parameter int NSLOT = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  combStrobe_t             strobe,
  input  logic [PIX_W-1:0]        inSrc,
  input  logic [PIX_W-1:0]        inDst,
  input  logic                    inXOdd,
  input  logic                    inYOdd,
  input  logic [2*PIX_W-1:0]      wrAddr,
  input  logic [PIX_W*NSLOT-1:0]  wrData,
  output logic [PIX_W-1:0]        outNib
);
  localparam int ADDR_W  = 2 * PIX_W;
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int ENTRY_W = PIX_W * NSLOT;
  localparam int SLOT_W  = $clog2(NSLOT);

  logic [ENTRY_W-1:0] tableMem [DEPTH];
  logic [ENTRY_W-1:0] rdEntry;
  logic [SLOT_W-1:0]  slotQ;
  logic [ADDR_W-1:0]  lookupIdx;
  logic [SLOT_W-1:0]  slotIdx;
  logic [PIX_W-1:0]   slotNib [NSLOT];

  // source nibble high, old destination nibble low
  assign lookupIdx = {inSrc, inDst};
  // slot = 2*yOdd + xOdd
  assign slotIdx = SLOT_W'({inYOdd, inXOdd});

  always_ff @(posedge clk) begin
    if (strobe.tblWrite) tableMem[wrAddr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdEntry <= '0;
      slotQ   <= '0;
    end else if (strobe.lookup) begin
      rdEntry <= tableMem[lookupIdx];
      slotQ   <= slotIdx;
    end
  end

  // slot 0 sits in the most significant nibble
  for (genvar g = 0; g < NSLOT; g++) begin : gSlot
    assign slotNib[g] = rdEntry[ENTRY_W-1-g*PIX_W -: PIX_W];
  end

  assign outNib = slotNib[slotQ];
endmodule

// File: rtl/nibble_texture_combine.sv
module nibble_texture_combine
  import nibcomb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output logic        inReady,
  input  logic [3:0]  inSrc,
  input  logic [3:0]  inDst,
  input  logic        inXOdd,
  input  logic        inYOdd,
  output logic        outValid,
  output logic [3:0]  outNib,
  input  logic        wrEn,
  input  logic [7:0]  wrAddr,
  input  logic [15:0] wrData
);
  combStrobe_t strobe;

  nibcomb_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .wrEn(wrEn),
    .inReady(inReady), .strobe(strobe), .outValid(outValid)
  );

  nibcomb_path #(.PIX_W(4), .NSLOT(4)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .inSrc(inSrc), .inDst(inDst), .inXOdd(inXOdd), .inYOdd(inYOdd),
    .wrAddr(wrAddr), .wrData(wrData), .outNib(outNib)
  );
endmodule

// File: rtl/nibcomb_checker.sv
module nibcomb_checker (
  input logic       clk,
  input logic       rstN,
  input logic       inValid,
  input logic       inReady,
  input logic       wrEn,
  input logic       outValid,
  input logic [3:0] outNib
);
  // R4: accepted pixel gives a result one cycle later
  a_r4_latency: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> outValid);

  // R4: no result without an accepted pixel
  a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !(inValid && inReady) |=> !outValid);

  // R6: host write blocks the pixel port
  a_r6_write_stalls: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> !inReady);

  // R6: a write cycle is never followed by a result
  a_r6_no_result_after_write: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !outValid);

  // R7: output nibble held between lookups
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(inValid && inReady) |=> $stable(outNib));

  // R8: reset forces outValid low
  a_r8_reset: assert property (@(posedge clk)
    !rstN |=> !outValid);
endmodule

bind nibble_texture_combine nibcomb_checker uChk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .wrEn(wrEn), .outValid(outValid), .outNib(outNib)
);

// File: tb/sim_nibble_texture_combine.sv
`timescale 1ns/1ps
module sim_nibble_texture_combine;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [3:0]  inSrc = '0;
  logic [3:0]  inDst = '0;
  logic        inXOdd = 1'b0;
  logic        inYOdd = 1'b0;
  logic        outValid;
  logic [3:0]  outNib;
  logic        wrEn = 1'b0;
  logic [7:0]  wrAddr = '0;
  logic [15:0] wrData = '0;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  nibble_texture_combine u0 (.*);

  // vectors: {src, dst, yOdd, xOdd}
  localparam logic [9:0] VEC [10] = '{
    {4'h0, 4'h0, 1'b0, 1'b0}, {4'h3, 4'hC, 1'b0, 1'b1},
    {4'hC, 4'h3, 1'b1, 1'b0}, {4'hF, 4'hF, 1'b1, 1'b1},
    {4'h5, 4'hA, 1'b0, 1'b0}, {4'hA, 4'h5, 1'b0, 1'b0},
    {4'h1, 4'h8, 1'b1, 1'b1}, {4'h8, 4'h1, 1'b1, 1'b1},
    {4'h7, 4'h2, 1'b0, 1'b1}, {4'h2, 4'h7, 1'b1, 1'b0}
  };

  function automatic logic [15:0] entryOf(input logic [7:0] a);
    logic [3:0] s0, s1, s2, s3;
    s0 = a[7:4] ^ a[3:0];
    s1 = a[7:4] + 4'd3;
    s2 = ~a[3:0];
    s3 = a[3:0] + a[7:4] + 4'd9;
    return {s0, s1, s2, s3};
  endfunction

  // R2/R3: slot = 2*y + x, slot 0 in bits 15:12
  function automatic logic [3:0] pickSlot(input logic [15:0] e, input logic y, input logic x);
    case ({y, x})
      2'b00:   return e[15:12];
      2'b01:   return e[11:8];
      2'b10:   return e[7:4];
      default: return e[3:0];
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic loadTable();
    for (int a = 0; a < 256; a++) begin
      @(negedge clk);
      wrEn = 1'b1; wrAddr = 8'(a); wrData = entryOf(8'(a));
    end
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  initial begin
    logic [3:0] held;
    logic [3:0] expPrev;
    repeat (3) @(negedge clk);
    // R8: reset state
    check(outValid == 1'b0, "R8 reset outValid", outValid, 0);
    check(inReady == 1'b1, "R6 ready idle", inReady, 1);
    rstN = 1'b1;

    loadTable();  // R5 load through host port
    @(negedge clk);
    check(outValid == 1'b0, "R8 no result before lookup", outValid, 0);

    // R1 R2 R3 R4: vector walk, back to back
    expPrev = '0;
    for (int i = 0; i <= 10; i++) begin
      @(negedge clk);
      if (i > 0) begin
        check(outValid == 1'b1, "R4 valid after accept", outValid, 1);
        check(outNib == expPrev, "R1 R2 R3 vector result", outNib, expPrev);
      end
      if (i < 10) begin
        inValid = 1'b1;
        {inSrc, inDst, inYOdd, inXOdd} = VEC[i];
        expPrev = pickSlot(entryOf({VEC[i][9:6], VEC[i][5:2]}), VEC[i][1], VEC[i][0]);
      end else inValid = 1'b0;
    end
    @(negedge clk);
    check(outValid == 1'b0, "R4 single-cycle pulse", outValid, 0);

    // R6 + R5: write collides with a lookup of the same address
    inValid = 1'b1; inSrc = 4'h9; inDst = 4'h4; inYOdd = 1'b1; inXOdd = 1'b0;
    wrEn = 1'b1; wrAddr = 8'h94; wrData = 16'hBEEF;
    #1;
    check(inReady == 1'b0, "R6 ready low during write", inReady, 0);
    @(negedge clk);
    check(outValid == 1'b0, "R6 lookup stalled", outValid, 0);
    wrEn = 1'b0;
    @(negedge clk);
    inValid = 1'b0;
    check(outValid == 1'b1, "R6 stalled lookup proceeds", outValid, 1);
    check(outNib == 4'hE, "R5 new data slot 2", outNib, 4'hE);

    // R7: output held while idle
    held = outNib;
    repeat (3) @(negedge clk);
    check(outNib == held, "R7 output held", outNib, held);
    check(outValid == 1'b0, "R7 no valid while idle", outValid, 0);

    // R9: one line, yOdd fixed at 1, xOdd toggling
    for (int i = 0; i <= 6; i++) begin
      @(negedge clk);
      if (i > 0) check(outNib == expPrev, "R9 line alternation", outNib, expPrev);
      if (i < 6) begin
        inValid = 1'b1; inSrc = 4'h6; inDst = 4'(i);
        inYOdd = 1'b1; inXOdd = i[0];
        expPrev = pickSlot(entryOf({4'h6, 4'(i)}), 1'b1, i[0]);
      end else inValid = 1'b0;
    end

    // R8: reset mid-run clears outValid
    @(negedge clk);
    inValid = 1'b1; inSrc = 4'h1; inDst = 4'h1;
    @(negedge clk);
    inValid = 1'b0;
    rstN = 1'b0;
    #1;
    check(outValid == 1'b0, "R8 reset clears valid", outValid, 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0, "R8 stays low after reset", outValid, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule